// File: doc/BRIEF.md
# Vectored Condition-Field Logic Sequencer

This block performs a bitwise logic operation over a run of elements held in a 32-bit condition register. The register is organised as eight 4-bit fields. A start strobe captures the register image, a decoded mode word, a vector length of up to eight, three operand indices, an operation code and a predicate mask. The block then executes one element per clock. Each element reads the register as the previous element left it, computes its result and writes it back. In bit mode, an element works on single bits that sit one field apart. In field mode, it works on whole 4-bit fields.

The loop can run forwards or in reverse. Because each element sees the previous write, overlapping operands cascade. A scalar-reduce mode holds the destination and the first source in place, so that an XOR across a vector yields parity. Masked elements are either skipped or written with zero. A data-dependent early-exit mode tests one bit of each result and stops at the first failure, reporting a truncated vector length that is derived from the test results alone.

The handshake is plain control, not a stream. A start pulse is accepted whenever the block is not busy. `busy_o` stays high for one cycle per executed element. `done_o` then stays high, and the final register and length stay frozen on the outputs, until the next start.

Top module: `crvec_seq`

## Requirements
- R1: Mode word bit map: mode_i[0]=zz, mode_i[1]=snz, mode_i[2]=early-exit select, mode_i[3..6]=the four shared bits. With mode_i[2]=0, mode_i[3] selects reverse order, mode_i[4] selects scalar reduce, mode_i[5] is dz and mode_i[6] is sz.
- R2: Operand indices are bit numbers 0..31, where bit n is cr bit n and field f holds bits 4f..4f+3. In bit mode (field_dst_i=0), element e uses bit base+4e of each operand. In field mode, element e uses field (base>>2)+e and the operation applies to all four bits. op_i codes: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR, 6 A AND NOT B, 7 A OR NOT B.
- R3: Elements execute strictly one after another, each reading the register state left by the previous element. With reverse order, the element sequence is VL-1 down to 0.
- R4: In scalar-reduce mode, the destination and operand A do not advance with the element number. Only operand B advances.
- R5: An element whose mask_i bit is 0 is skipped, leaving the destination unchanged, when dz=0. When dz=1, it writes zero to the destination.
- R6: In early-exit mode, the tested bit is the written bit in bit mode. In field mode, it is bit sel of the written field, where sel={mode_i[6],mode_i[5]}. The test fails when the bit equals the invert flag mode_i[4]. The failing element is written and no later element executes.
- R7: In early-exit mode, mode_i[3] set makes the new length count the failing step (step number + 1). Clear, the new length is the step number. With no failure, or outside early-exit mode, the new length equals VL.
- R8: In early-exit mode, field-mode dz and sz both equal zz (mode_i[0]), while bit-mode dz and sz come from mode_i[5] and mode_i[6]. A zeroed masked element tests as 1 when sz and snz are both set, and as 0 otherwise. A skipped element is not tested.
- R9: If VL>8 or any operand's last address lies beyond bit 31 or field 7, err_o is raised with done_o, nothing is written, the new length is 0, and busy_o lasts one cycle.
- R10: VL=0 completes after one busy cycle with no write, no error and a new length of 0.
- R11: After reset, busy_o, done_o and err_o are 0 and cr_o and new_vl_o are 0. busy_o lasts exactly one cycle per executed element. done_o, cr_o and new_vl_o hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when not busy |
| mode_i | input | 7 | Packed mode word (R1, R8) |
| field_dst_i | input | 1 | 1: whole-field operands, 0: single-bit operands |
| op_i | input | 3 | Logic operation code |
| vl_i | input | 4 | Vector length, 0..8 |
| ba_i | input | 5 | Operand A base bit index |
| bb_i | input | 5 | Operand B base bit index |
| bt_i | input | 5 | Destination base bit index |
| mask_i | input | 8 | Predicate mask, bit e for element e |
| cr_i | input | 32 | Register image captured at start |
| busy_o | output | 1 | Elements are executing |
| done_o | output | 1 | Run finished, results held |
| err_o | output | 1 | Address or length out of range |
| cr_o | output | 32 | Current register image |
| new_vl_o | output | 4 | Resulting vector length |

## Verification
The bench targets the overlap cascade under reverse order. A design that snapshots the register at start, or that ignores the order flag, leaves the lower destination fields set instead of cleared. For early exit, it runs the inclusive and exclusive length rules, the inverted test, the field selector and the zz/snz substitution for masked elements. A wrong choice of test bit, or testing a skipped element, shows up as a truncated length that is off by one or comes too early. It also runs parity reduction, the zero-versus-skip mask behaviour, and out-of-range operands in both addressing modes. A design that writes before range-checking would corrupt the held image there.

// File: rtl/crvec_pkg.sv
package crvec_pkg;
  localparam int unsigned FLD_W  = 4;
  localparam int unsigned SEL_W  = $clog2(FLD_W);
  localparam int unsigned MODE_W = 7;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_NAND = 3'd3,
    OP_NOR  = 3'd4,
    OP_XNOR = 3'd5,
    OP_ANDC = 3'd6,
    OP_ORC  = 3'd7
  } crop_e;

  typedef struct packed {
    logic             ff;
    logic             rev;
    logic             reduce;
    logic             dz;
    logic             sz;
    logic             vli;
    logic             inv;
    logic             snz;
    logic [SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/crvec_decode.sv
module crvec_decode
  import crvec_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              field_dst_i,
  output ctl_t              ctl_o
);
  always_comb begin
    ctl_o    = '0;
    ctl_o.ff = mode_i[2];
    if (!mode_i[2]) begin
      ctl_o.rev    = mode_i[3];
      ctl_o.reduce = mode_i[4];
      ctl_o.dz     = mode_i[5];
      ctl_o.sz     = mode_i[6];
    end else begin
      ctl_o.vli = mode_i[3];
      ctl_o.inv = mode_i[4];
      ctl_o.snz = mode_i[1];
      if (field_dst_i) begin
        ctl_o.sel = mode_i[6:5];
        ctl_o.dz  = mode_i[0];
        ctl_o.sz  = mode_i[0];
      end else begin
        ctl_o.dz  = mode_i[5];
        ctl_o.sz  = mode_i[6];
      end
    end
  end
endmodule

// File: rtl/crvec_alu.sv
module crvec_alu
  import crvec_pkg::*;
(
  input  crop_e             op_i,
  input  logic [FLD_W-1:0]  a_i,
  input  logic [FLD_W-1:0]  b_i,
  output logic [FLD_W-1:0]  y_o
);
  always_comb begin
    case (op_i)
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_NAND: y_o = ~(a_i & b_i);
      OP_NOR:  y_o = ~(a_i | b_i);
      OP_XNOR: y_o = ~(a_i ^ b_i);
      OP_ANDC: y_o = a_i & ~b_i;
      OP_ORC:  y_o = a_i | ~b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/crvec_addr.sv
module crvec_addr
  import crvec_pkg::*;
#(
  parameter int unsigned NF = 8,
  localparam int unsigned EW = $clog2(NF),
  localparam int unsigned IW = EW + SEL_W
) (
  input  logic          field_i,
  input  logic          stride_i,
  input  logic [IW-1:0] base_i,
  input  logic [EW-1:0] elem_i,
  input  logic [EW-1:0] last_i,
  output logic [IW-1:0] addr_o,
  output logic          ok_o
);
  function automatic logic [IW:0] locate(input logic fld, input logic strd,
                                         input logic [IW-1:0] b,
                                         input logic [EW-1:0] e);
    logic [IW:0] step;
    logic [IW:0] org;
    step = strd ? ({{(SEL_W+1){1'b0}}, e} << SEL_W) : '0;
    org  = fld ? {1'b0, b[IW-1:SEL_W], {SEL_W{1'b0}}} : {1'b0, b};
    return org + step;
  endfunction

  logic [IW:0] cur;
  logic [IW:0] fin;

  assign cur    = locate(field_i, stride_i, base_i, elem_i);
  assign fin    = locate(field_i, stride_i, base_i, last_i);
  assign addr_o = cur[IW-1:0];
  assign ok_o   = ~fin[IW];
endmodule

// File: rtl/crvec_seq.sv
module crvec_seq
  import crvec_pkg::*;
#(
  parameter int unsigned NF = 8,
  localparam int unsigned EW  = $clog2(NF),
  localparam int unsigned IW  = EW + SEL_W,
  localparam int unsigned CRW = NF * FLD_W,
  localparam int unsigned VLW = $clog2(NF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              field_dst_i,
  input  logic [2:0]        op_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [IW-1:0]     ba_i,
  input  logic [IW-1:0]     bb_i,
  input  logic [IW-1:0]     bt_i,
  input  logic [NF-1:0]     mask_i,
  input  logic [CRW-1:0]    cr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CRW-1:0]    cr_o,
  output logic [VLW-1:0]    new_vl_o
);
  localparam int unsigned NOPND = 3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  st_e                         st_q;
  logic [NF-1:0][FLD_W-1:0]    cr_q, cr_n;
  ctl_t                        ctl_q, ctl_d;
  logic                        fld_q;
  crop_e                       op_q;
  logic [VLW-1:0]              vl_q, nvl_q;
  logic [NOPND-1:0][IW-1:0]    base_q;
  logic [NF-1:0]               mask_q;
  logic [EW-1:0]               k_q;
  logic                        err_q;

  // decode of the mode word on the start cycle
  crvec_decode u_dec (
    .mode_i      (mode_i),
    .field_dst_i (field_dst_i),
    .ctl_o       (ctl_d)
  );

  // element sequencing
  logic [EW-1:0] last_el, elem;
  assign last_el = EW'(vl_q - VLW'(1));
  assign elem    = ctl_q.rev ? EW'(last_el - k_q) : k_q;

  // per-operand address generation: 0 = A, 1 = B, 2 = destination
  logic [NOPND-1:0][IW-1:0] addr;
  logic [NOPND-1:0]         ok;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    crvec_addr #(.NF(NF)) u_addr (
      .field_i  (fld_q),
      .stride_i ((g == 1) ? 1'b1 : !ctl_q.reduce),
      .base_i   (base_q[g]),
      .elem_i   (elem),
      .last_i   (last_el),
      .addr_o   (addr[g]),
      .ok_o     (ok[g])
    );
  end

  // operand read
  logic [FLD_W-1:0] opa, opb, res;

  always_comb begin
    if (fld_q) begin
      opa = cr_q[addr[0][IW-1:SEL_W]];
      opb = cr_q[addr[1][IW-1:SEL_W]];
    end else begin
      opa = {{(FLD_W-1){1'b0}}, cr_q[addr[0][IW-1:SEL_W]][addr[0][SEL_W-1:0]]};
      opb = {{(FLD_W-1){1'b0}}, cr_q[addr[1][IW-1:SEL_W]][addr[1][SEL_W-1:0]]};
    end
  end

  crvec_alu u_alu (
    .op_i (op_q),
    .a_i  (opa),
    .b_i  (opb),
    .y_o  (res)
  );

  // predicate, write-back and early-exit test
  logic             pred, wr, tested, tbit, fail, bad;
  logic [FLD_W-1:0] wval;

  always_comb begin
    pred   = mask_q[elem];
    wr     = pred || ctl_q.dz;
    tested = ctl_q.ff && wr;
    wval   = pred ? res : '0;
    if (pred) tbit = fld_q ? res[ctl_q.sel] : res[0];
    else      tbit = ctl_q.sz && ctl_q.snz;
    fail   = tested && (tbit == ctl_q.inv);
    cr_n   = cr_q;
    if (wr) begin
      if (fld_q) cr_n[addr[2][IW-1:SEL_W]] = wval;
      else       cr_n[addr[2][IW-1:SEL_W]][addr[2][SEL_W-1:0]] = wval[0];
    end
  end

  assign bad = (vl_q == '0) || (vl_q > VLW'(NF)) || !(&ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cr_q   <= '0;
      ctl_q  <= '0;
      fld_q  <= 1'b0;
      op_q   <= OP_AND;
      vl_q   <= '0;
      nvl_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      k_q    <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE, S_FIN: begin
          if (start_i) begin
            st_q   <= S_RUN;
            cr_q   <= cr_i;
            ctl_q  <= ctl_d;
            fld_q  <= field_dst_i;
            op_q   <= crop_e'(op_i);
            vl_q   <= vl_i;
            base_q <= {bt_i, bb_i, ba_i};
            mask_q <= mask_i;
            k_q    <= '0;
            err_q  <= 1'b0;
            nvl_q  <= '0;
          end
        end
        S_RUN: begin
          if (k_q == '0 && bad) begin
            st_q  <= S_FIN;
            nvl_q <= '0;
            err_q <= (vl_q != '0);
          end else begin
            cr_q <= cr_n;
            if (fail) begin
              st_q  <= S_FIN;
              nvl_q <= ctl_q.vli ? VLW'(k_q) + VLW'(1) : VLW'(k_q);
            end else if (k_q == last_el) begin
              st_q  <= S_FIN;
              nvl_q <= vl_q;
            end else begin
              k_q <= k_q + EW'(1);
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q == S_RUN);
  assign done_o   = (st_q == S_FIN);
  assign err_o    = err_q;
  assign cr_o     = cr_q;
  assign new_vl_o = nvl_q;
endmodule

// File: rtl/crvec_seq_chk.sv
module crvec_seq_chk #(
  parameter int unsigned NF = 8,
  localparam int unsigned CRW = NF * 4,
  localparam int unsigned VLW = $clog2(NF + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           err_o,
  input logic [CRW-1:0] cr_o,
  input logic [VLW-1:0] new_vl_o
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= busy_o ? run_len + 8'd1 : 8'd0;
  end

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(cr_o) && $stable(new_vl_o)));

  assert_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 8'(NF));

  assert_continue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  assert_onefield_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($countones(cr_o ^ $past(cr_o)) <= 4));

  assert_newvl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (new_vl_o <= VLW'(NF)));

  assert_errdone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && new_vl_o == '0));
endmodule

bind crvec_seq crvec_seq_chk #(.NF(NF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .cr_o     (cr_o),
  .new_vl_o (new_vl_o)
);

// File: tb/sim_crvec_seq.sv
module sim_crvec_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  mode_i = '0;
  logic        field_dst_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [3:0]  vl_i = '0;
  logic [4:0]  ba_i = '0, bb_i = '0, bt_i = '0;
  logic [7:0]  mask_i = '0;
  logic [31:0] cr_i = '0;
  logic        busy_o, done_o, err_o;
  logic [31:0] cr_o;
  logic [3:0]  new_vl_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  crvec_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .field_dst_i(field_dst_i), .op_i(op_i), .vl_i(vl_i), .ba_i(ba_i),
    .bb_i(bb_i), .bt_i(bt_i), .mask_i(mask_i), .cr_i(cr_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .cr_o(cr_o),
    .new_vl_o(new_vl_o)
  );

  typedef struct {
    logic [31:0] cr;
    logic [3:0]  nvl;
    logic        err;
    int          steps;
    string       tag;
  } exp_t;

  exp_t  expq[$];
  int    pending = 0;
  int    checks = 0;
  int    errors = 0;
  bit    reported = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  function automatic int loc(bit fld, int base, int st, int e);
    return fld ? 4 * (base / 4 + st * e) : base + 4 * st * e;
  endfunction

  function automatic logic [3:0] lop(logic [2:0] op, logic [3:0] a, logic [3:0] b);
    case (op)
      3'd0: return a & b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return ~(a & b);
      3'd4: return ~(a | b);
      3'd5: return ~(a ^ b);
      3'd6: return a & ~b;
      default: return a | ~b;
    endcase
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(string tag, logic [6:0] m, bit fld, logic [2:0] op,
                                 int vl, int ba, int bb, int bt,
                                 logic [7:0] mask, logic [31:0] cr);
    exp_t x;
    bit ff, rev, red, dz, sz, vli, inv, snz, bad;
    int sel;
    int bases[3];
    int st[3];
    ff = m[2]; rev = 0; red = 0; vli = 0; inv = 0; snz = 0; sel = 0;
    if (!ff) begin
      rev = m[3]; red = m[4]; dz = m[5]; sz = m[6];
    end else begin
      vli = m[3]; inv = m[4]; snz = m[1];
      if (fld) begin sel = {m[6], m[5]}; dz = m[0]; sz = m[0]; end
      else begin dz = m[5]; sz = m[6]; end
    end
    x.tag = tag; x.cr = cr; x.nvl = 0; x.err = 0; x.steps = 1;
    if (vl == 0) return x;
    bases[0] = ba; bases[1] = bb; bases[2] = bt;
    st[0] = red ? 0 : 1; st[1] = 1; st[2] = red ? 0 : 1;
    bad = (vl > 8);
    for (int g = 0; g < 3; g++)
      if (loc(fld, bases[g], st[g], vl - 1) > 31) bad = 1;
    if (bad) begin x.err = 1; return x; end
    x.nvl = 4'(vl);
    for (int k = 0; k < vl; k++) begin
      int e;
      int ad[3];
      logic [3:0] a, b, y;
      bit p, tb;
      e = rev ? vl - 1 - k : k;
      for (int g = 0; g < 3; g++) ad[g] = loc(fld, bases[g], st[g], e);
      if (fld) begin a = x.cr[ad[0] +: 4]; b = x.cr[ad[1] +: 4]; end
      else begin a = {3'b0, x.cr[ad[0]]}; b = {3'b0, x.cr[ad[1]]}; end
      y = lop(op, a, b);
      p = mask[e];
      x.steps = k + 1;
      if (!p && !dz) continue;
      if (!p) y = '0;
      if (fld) x.cr[ad[2] +: 4] = y;
      else     x.cr[ad[2]] = y[0];
      if (ff) begin
        tb = p ? (fld ? y[sel] : y[0]) : (sz && snz);
        if (tb == inv) begin
          x.nvl = vli ? 4'(k + 1) : 4'(k);
          return x;
        end
      end
    end
    return x;
  endfunction

  task automatic run_case(string tag, logic [6:0] m, bit fld, logic [2:0] op,
                          int vl, int ba, int bb, int bt,
                          logic [7:0] mask, logic [31:0] cr);
    exp_t x;
    x = model(tag, m, fld, op, vl, ba, bb, bt, mask, cr);
    expq.push_back(x);
    pending++;
    @(negedge clk);
    mode_i = m; field_dst_i = fld; op_i = op; vl_i = 4'(vl);
    ba_i = 5'(ba); bb_i = 5'(bb); bt_i = 5'(bt); mask_i = mask; cr_i = cr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait (pending == 0);
    repeat (3) @(negedge clk);
    check(done_o && cr_o == x.cr, {tag, " R11 hold"}, "cr_o", cr_o, x.cr);
  endtask

  // monitor / scoreboard
  initial begin
    int  busy_cnt;
    bit  done_prev;
    busy_cnt = 0;
    done_prev = 0;
    forever begin
      @(negedge clk);
      if (busy_o) busy_cnt++;
      if (done_o && !done_prev && expq.size() > 0) begin
        exp_t x;
        x = expq.pop_front();
        check(cr_o == x.cr, x.tag, "cr_o", cr_o, x.cr);
        check(new_vl_o == x.nvl, x.tag, "new_vl_o", new_vl_o, x.nvl);
        check(err_o == x.err, x.tag, "err_o", err_o, x.err);
        check(busy_cnt == x.steps, x.tag, "busy cycles R11", busy_cnt, x.steps);
        busy_cnt = 0;
        pending--;
      end
      done_prev = done_o;
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !err_o, "R11 reset", "flags", {busy_o, done_o, err_o}, 0);
    check(cr_o == '0 && new_vl_o == '0, "R11 reset", "cr_o", cr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R11 idle", "busy/done", {busy_o, done_o}, 0);

    run_case("R2 bit AND",        7'b0000000, 0, 3'd0, 4, 1, 2, 3, 8'hFF, 32'hA5C3_5F1E);
    run_case("R2 field XOR",      7'b0000000, 1, 3'd2, 3, 0, 12, 20, 8'hFF, 32'h1234_5678);
    run_case("R2 bit ORC",        7'b0000000, 0, 3'd7, 5, 0, 1, 2, 8'hFF, 32'h0F0F_0F0F);
    run_case("R3 reverse cascade",7'b0001000, 0, 3'd0, 7, 2, 6, 2, 8'hFF, 32'hFFFF_FBFF);
    run_case("R3 forward overlap",7'b0000000, 0, 3'd0, 7, 2, 6, 2, 8'hFF, 32'hFFFF_FBFF);
    run_case("R4 R1 parity",      7'b0010000, 0, 3'd2, 8, 0, 1, 0, 8'hFF, 32'h2222_0220);
    run_case("R5 skip",           7'b0000000, 0, 3'd1, 4, 0, 1, 2, 8'b0000_0101, 32'h3333_3333);
    run_case("R5 R1 zero",        7'b0100000, 0, 3'd1, 4, 0, 1, 2, 8'b0000_0101, 32'h3333_3333);
    run_case("R6 R7 exclusive",   7'b0000100, 0, 3'd0, 6, 0, 1, 2, 8'hFF, 32'h0033_3133);
    run_case("R7 inclusive",      7'b0001100, 0, 3'd0, 6, 0, 1, 2, 8'hFF, 32'h0033_3133);
    run_case("R6 inverted",       7'b0010100, 0, 3'd0, 6, 0, 1, 2, 8'hFF, 32'h0033_3133);
    run_case("R7 no failure",     7'b0000100, 0, 3'd1, 5, 0, 1, 2, 8'hFF, 32'h0003_3333);
    run_case("R6 field sel",      7'b1000100, 1, 3'd1, 4, 0, 16, 16, 8'hFF, 32'h4144_0000);
    run_case("R8 zz snz",         7'b1000111, 1, 3'd1, 4, 0, 16, 16, 8'b1111_1101, 32'h4144_0000);
    run_case("R8 zz no snz",      7'b1000101, 1, 3'd1, 4, 0, 16, 16, 8'b1111_1101, 32'h4144_0000);
    run_case("R8 skip untested",  7'b0000100, 0, 3'd0, 6, 0, 1, 2, 8'b1111_1011, 32'h0033_3133);
    run_case("R8 bit dz sz snz",  7'b1100110, 0, 3'd0, 4, 0, 1, 2, 8'b1111_1011, 32'h0033_3333);
    run_case("R9 bit range",      7'b0000000, 0, 3'd0, 2, 0, 1, 29, 8'hFF, 32'hDEAD_BEEF);
    run_case("R9 field range",    7'b0000000, 1, 3'd1, 3, 24, 0, 4, 8'hFF, 32'hCAFE_F00D);
    run_case("R9 length",         7'b0000000, 0, 3'd0, 9, 0, 0, 0, 8'hFF, 32'h1357_9BDF);
    run_case("R10 empty",         7'b0000000, 0, 3'd2, 0, 0, 1, 2, 8'hFF, 32'h2468_ACE0);

    report();
    $finish;
  end
endmodule